// File: doc/BRIEF.md
# OFDMA Downlink Preamble Sub-carrier Mapper

This block produces the frequency-domain contents of one downlink preamble symbol for a 2048-point OFDMA transmitter. After a start strobe it walks through every FFT bin from index 0 up to 2047, one bin per clock, and for each bin presents the bin index, a valid flag and a signed I/Q pair ready to be written into an IFFT input buffer.

The spectrum has 172 zero guard bins on each edge. The 1704 bins between them form the used region. A segment's preamble occupies every third used bin, starting at an offset of 0, 1 or 2 given by the carrier-set select, which is captured when the symbol starts. Those bins carry BPSK at a boosted amplitude, with the sign taken from a PN bit stream supplied by an external source. The block asks for a PN bit only on bins of the chosen set. The DC bin (index 1024) falls in set 0. On that bin the block still takes its PN bit but drives zero. A one-cycle done pulse follows the last bin.

Top module: `ofdma_preamble_mapper`

## Requirements
- R1: While reset is held and while the block is idle, `out_valid`, `done` and `pn_req` are 0 and `out_i` is 0.
- R2: When `start` is high in an idle cycle, bin 0 appears on the outputs two clock edges later. Bins 0 to 2047 then follow on consecutive cycles, in ascending order, with `out_valid` high.
- R3: Bins 0 to 171 and bins 1876 to 2047 are always output as zero.
- R4: A bin b in the range 172 to 1875 belongs to the selected set when (b − 172) mod 3 equals the select value. Only bins of that set, other than bin 1024, carry a nonzero I value.
- R5: `pn_req` is high in the cycle one clock before bin b is output exactly when b belongs to the selected set. The `pn_bit` sampled in that cycle sets the output: 0 gives +BOOST and 1 gives −BOOST on I, where BOOST defaults to 21845 (8/3 of a unit amplitude of 8192).
- R6: Bin 1024 is output as zero. For select 0, its PN bit is still requested and dropped, so each of selects 0, 1 and 2 requests exactly 568 PN bits per symbol.
- R7: `out_q` is zero on every bin.
- R8: `done` is high for exactly one cycle, the cycle after bin 2047 is output. In that cycle `out_valid` is low.
- R9: A `start` while a symbol is being produced, including in the cycle of the last bin, has no effect. Changing `set_sel` after the start does not change the symbol.
- R10: A select value of 3 matches no bin. Every output bin is zero and no PN bit is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| start | input | 1 | Begins a symbol when the block is idle |
| set_sel | input | 2 | Carrier-set offset (0..2), captured at start |
| pn_bit | input | 1 | PN bit, sampled in cycles where pn_req is high |
| pn_req | output | 1 | Requests a PN bit for the current bin |
| out_valid | output | 1 | Output bin valid |
| out_bin | output | 11 | FFT bin index of the output |
| out_i | output | 16 | Signed in-phase value |
| out_q | output | 16 | Signed quadrature value (zero) |
| done | output | 1 | One-cycle pulse after bin 2047 |

## Verification
The hardest case to reach from the ports is the DC bin under select 0. The bin must read zero, yet its PN bit must still be consumed, and the only evidence of that is the request count and the alignment of every later set bin with its PN bit. The stimulus covers it by running directed symbols with each select and keeping a per-symbol request count. It also drives a fresh random PN bit every cycle, so a slip of even one bit shows up as a sign error past bin 1024. Random symbols also toggle the select and fire stray start strobes mid-symbol. One directed symbol strobes start exactly on the last bin.

// File: rtl/ofdma_pre_pkg.sv
package ofdma_pre_pkg;
  // classification of the bin currently addressed by the sequencer
  typedef struct packed {
    logic take_pn;  // bin belongs to the chosen carrier set
    logic on_dc;    // bin is the DC bin
    logic fill;     // bin carries a nonzero BPSK value
  } bin_class_t;
endpackage

// File: rtl/pre_rst_sync.sv
module pre_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/pre_bin_seq.sv
module pre_bin_seq #(
  parameter int N_FFT   = 2048,
  parameter int GUARD_L = 172,
  parameter int GUARD_R = 172,
  parameter int N_SETS  = 3,
  parameter int BIN_W   = $clog2(N_FFT),
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel_in,
  output logic             active,
  output logic [BIN_W-1:0] cnt,
  output logic [SEL_W-1:0] phase,
  output logic [SEL_W-1:0] sel_q,
  output logic             in_used
);
  localparam logic [BIN_W-1:0] LAST_BIN  = BIN_W'(N_FFT - 1);
  localparam logic [BIN_W-1:0] USED_LO   = BIN_W'(GUARD_L);
  localparam logic [BIN_W-1:0] USED_HI   = BIN_W'(N_FFT - GUARD_R - 1);
  localparam logic [SEL_W-1:0] PHASE_TOP = SEL_W'(N_SETS - 1);

  logic             act_d;
  logic [BIN_W-1:0] cnt_d;
  logic [SEL_W-1:0] ph_d, sel_d;
  logic             clk_en;

  assign in_used = (cnt >= USED_LO) && (cnt <= USED_HI);
  assign clk_en  = start | active;

  always_comb begin
    act_d = active;
    cnt_d = cnt;
    ph_d  = phase;
    sel_d = sel_q;
    if (!active) begin
      if (start) begin
        act_d = 1'b1;
        cnt_d = '0;
        ph_d  = '0;
        sel_d = sel_in;
      end
    end else begin
      cnt_d = cnt + 1'b1;
      if (in_used) ph_d = (phase == PHASE_TOP) ? '0 : phase + 1'b1;
      if (cnt == LAST_BIN) begin
        act_d = 1'b0;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      phase  <= '0;
      sel_q  <= '0;
    end else if (clk_en) begin
      active <= act_d;
      cnt    <= cnt_d;
      phase  <= ph_d;
      sel_q  <= sel_d;
    end
  end

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PHASE_TOP);

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(sel_q));
endmodule

// File: rtl/pre_set_class.sv
module pre_set_class
  import ofdma_pre_pkg::*;
#(
  parameter int N_FFT = 2048,
  parameter int BIN_W = $clog2(N_FFT),
  parameter int SEL_W = 2
) (
  input  logic             active,
  input  logic             in_used,
  input  logic [BIN_W-1:0] cnt,
  input  logic [SEL_W-1:0] phase,
  input  logic [SEL_W-1:0] sel_q,
  output bin_class_t       cls
);
  localparam logic [BIN_W-1:0] DC_BIN = BIN_W'(N_FFT / 2);

  always_comb begin
    cls.take_pn = active & in_used & (phase == sel_q);
    cls.on_dc   = (cnt == DC_BIN);
    cls.fill    = cls.take_pn & ~cls.on_dc;
  end
endmodule

// File: rtl/pre_out_stage.sv
module pre_out_stage
  import ofdma_pre_pkg::*;
#(
  parameter int N_FFT   = 2048,
  parameter int GUARD_L = 172,
  parameter int GUARD_R = 172,
  parameter int BIN_W   = $clog2(N_FFT),
  parameter int IQ_W    = 16,
  parameter int BOOST   = 21845
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic [BIN_W-1:0]       cnt,
  input  bin_class_t             cls,
  input  logic                   pn_bit,
  output logic                   out_valid,
  output logic [BIN_W-1:0]       out_bin,
  output logic signed [IQ_W-1:0] out_i,
  output logic                   done
);
  localparam logic [BIN_W-1:0]       LAST_BIN = BIN_W'(N_FFT - 1);
  localparam logic [BIN_W-1:0]       DC_BIN   = BIN_W'(N_FFT / 2);
  localparam logic [BIN_W-1:0]       USED_LO  = BIN_W'(GUARD_L);
  localparam logic [BIN_W-1:0]       USED_HI  = BIN_W'(N_FFT - GUARD_R - 1);
  localparam logic signed [IQ_W-1:0] POS_AMP  = IQ_W'(BOOST);
  localparam logic signed [IQ_W-1:0] NEG_AMP  = -POS_AMP;

  logic                   val_d, done_d;
  logic [BIN_W-1:0]       bin_d;
  logic signed [IQ_W-1:0] i_d;

  always_comb begin
    val_d  = active;
    bin_d  = active ? cnt : out_bin;
    i_d    = '0;
    if (cls.fill) i_d = pn_bit ? NEG_AMP : POS_AMP;
    done_d = out_valid && (out_bin == LAST_BIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bin   <= '0;
      out_i     <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= val_d;
      out_bin   <= bin_d;
      out_i     <= i_d;
      done      <= done_d;
    end
  end

  // R2
  bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_bin == $past(out_bin) + 1'b1));

  // R3
  guard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((out_bin < USED_LO) || (out_bin > USED_HI))) |-> (out_i == '0));

  // R6
  dc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_bin == DC_BIN)) |-> (out_i == '0));

  // R5
  amp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_i != '0) |-> (out_valid && ((out_i == POS_AMP) || (out_i == NEG_AMP))));

  // R8
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

// File: rtl/ofdma_preamble_mapper.sv
module ofdma_preamble_mapper
  import ofdma_pre_pkg::*;
#(
  parameter int N_FFT   = 2048,
  parameter int GUARD_L = 172,
  parameter int GUARD_R = 172,
  parameter int N_SETS  = 3,
  parameter int IQ_W    = 16,
  parameter int UNIT    = 8192,
  parameter int BOOST   = (8 * UNIT) / 3,
  parameter int BIN_W   = $clog2(N_FFT),
  parameter int SEL_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SEL_W-1:0]       set_sel,
  input  logic                   pn_bit,
  output logic                   pn_req,
  output logic                   out_valid,
  output logic [BIN_W-1:0]       out_bin,
  output logic signed [IQ_W-1:0] out_i,
  output logic signed [IQ_W-1:0] out_q,
  output logic                   done
);
  logic             rst_sync_n;
  logic             active, in_used;
  logic [BIN_W-1:0] cnt;
  logic [SEL_W-1:0] phase, sel_q;
  bin_class_t       cls;

  pre_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pre_bin_seq #(
    .N_FFT(N_FFT), .GUARD_L(GUARD_L), .GUARD_R(GUARD_R),
    .N_SETS(N_SETS), .BIN_W(BIN_W), .SEL_W(SEL_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .sel_in  (set_sel),
    .active  (active),
    .cnt     (cnt),
    .phase   (phase),
    .sel_q   (sel_q),
    .in_used (in_used)
  );

  pre_set_class #(
    .N_FFT(N_FFT), .BIN_W(BIN_W), .SEL_W(SEL_W)
  ) u_cls (
    .active  (active),
    .in_used (in_used),
    .cnt     (cnt),
    .phase   (phase),
    .sel_q   (sel_q),
    .cls     (cls)
  );

  pre_out_stage #(
    .N_FFT(N_FFT), .GUARD_L(GUARD_L), .GUARD_R(GUARD_R),
    .BIN_W(BIN_W), .IQ_W(IQ_W), .BOOST(BOOST)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (active),
    .cnt       (cnt),
    .cls       (cls),
    .pn_bit    (pn_bit),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .out_i     (out_i),
    .done      (done)
  );

  assign pn_req = cls.take_pn;
  assign out_q  = '0;

  // R5
  req_active_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pn_req |=> out_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> (out_i == '0));
endmodule

// File: tb/ofdma_preamble_mapper_bench.sv
module ofdma_preamble_mapper_bench;
  localparam int N    = 2048;
  localparam int GL   = 172;
  localparam int GR   = 172;
  localparam int DC   = 1024;
  localparam int AMP  = 21845;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [1:0]         set_sel;
  logic               pn_bit;
  logic               pn_req, out_valid, done;
  logic [10:0]        out_bin;
  logic signed [15:0] out_i, out_q;

  int n_vec  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ofdma_preamble_mapper u_ofdma_preamble_mapper (
    .clk(clk), .rst_n(rst_n), .start(start), .set_sel(set_sel),
    .pn_bit(pn_bit), .pn_req(pn_req), .out_valid(out_valid),
    .out_bin(out_bin), .out_i(out_i), .out_q(out_q), .done(done)
  );

  function automatic bit in_set(int b, int sel);
    if (b < GL || b > N - GR - 1) return 1'b0;
    return ((b - GL) % 3) == sel;
  endfunction

  function automatic int exp_val(int b, int sel, bit bitv);
    if (!in_set(b, sel) || b == DC) return 0;
    return bitv ? -AMP : AMP;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    chk(out_valid == 1'b0, req, out_valid, 0);
    chk(pn_req == 1'b0, req, pn_req, 0);
    chk(out_i == 16'sd0, req, out_i, 0);
    chk(done == 1'b0, req, done, 0);
  endtask

  // one full symbol; noisy toggles select and stray starts, late fires start on the last bin
  task automatic run_symbol(int sel, bit noisy, bit late);
    int reqs = 0;
    int expv = 0;
    set_sel = 2'(sel);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int b = 0; b <= N; b++) begin
      if (b > 0) begin
        chk(out_valid == 1'b1, "R2", out_valid, 1);
        chk(int'(out_bin) == b - 1, "R2", out_bin, b - 1);
        if (b - 1 < GL || b - 1 > N - GR - 1)
          chk(int'(out_i) == expv, "R3", out_i, expv);
        else if (b - 1 == DC)
          chk(int'(out_i) == expv, "R6", out_i, expv);
        else if (sel == 3)
          chk(int'(out_i) == expv, "R10", out_i, expv);
        else
          chk(int'(out_i) == expv, "R4", out_i, expv);
        chk(out_q == 16'sd0, "R7", out_q, 0);
        chk(done == 1'b0, "R8", done, 0);
      end
      if (b < N) begin
        chk(pn_req == in_set(b, sel), "R5", pn_req, in_set(b, sel));
        if (pn_req) reqs++;
        pn_bit = 1'($urandom);
        expv   = exp_val(b, sel, pn_bit);
        if (noisy) begin
          set_sel = 2'($urandom);
          start   = (($urandom % 16) == 0);
        end
        if (late && b == N - 1) start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(done == 1'b1, "R8", done, 1);
    chk(out_valid == 1'b0, "R9", out_valid, 0);
    chk(reqs == ((sel == 3) ? 0 : 568), (sel == 3) ? "R10" : "R6", reqs, (sel == 3) ? 0 : 568);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    check_idle("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n   = 1'b0;
    start   = 1'b0;
    set_sel = 2'd0;
    pn_bit  = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    run_symbol(1, 1'b0, 1'b0);
    run_symbol(0, 1'b0, 1'b0);  // DC bin in set 0: R6
    run_symbol(2, 1'b0, 1'b1);  // start on last bin ignored: R9
    run_symbol(3, 1'b0, 1'b0);  // R10
    for (int s = 0; s < 4; s++) begin
      run_symbol(int'($urandom % 4), 1'b1, 1'b0);
      repeat (int'($urandom % 3)) begin
        @(negedge clk);
        check_idle("R1");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule